// File: doc/BRIEF.md
# Halt, Wake-up and Reset-Cause Controller

This block handles the low-power halt state of a small processor. In normal run it keeps the system clock enabled. A halt request switches the clock gate off, sends a clear pulse to the watchdog so that it counts again from zero, and records the halt in a power-down flag. All processor state stays as it is. While halted, the block watches four kinds of wake source. The first is falling edges on the bits of an 8-bit port that have their wake-enable bit set. The second is interrupt requests that were not already pending when the halt began. The third is a watchdog overflow, and the fourth is an external reset pin. When one of these arrives, the block picks the single winner of that cycle and starts a fixed start-up delay. When the delay ends, it either releases a reset or issues a one-cycle strobe that tells the core to resume at the next instruction or to take the interrupt.

The block also keeps two status flags, time-out and power-down. Together they let software tell apart the causes of the last reset. A watchdog overflow while halted is reported as a warm reset, which reloads only the program counter and stack pointer. The other reset causes (power-up, the external pin, and a watchdog overflow in normal run) are reported as cold resets. The synchronous `rst` input acts exactly like a power-up event.

Top module: `halt_wake_ctrl`

## Requirements
- R1: In normal run, a halt request (with no reset or overflow in the same cycle) makes the next cycle show `clk_en_o`=0, `pd_flag_o`=1, `to_flag_o`=0 and a `wdt_clr_o` pulse exactly one cycle long.
- R2: In normal run, the watchdog-clear command clears `pd_flag_o` on the next cycle. While halted, the command has no effect on the flags.
- R3: Power-up (`rst` or `por_i`, from any state) sets both flags to 0 and holds `cold_rst_o`=1 and `clk_en_o`=0 for the whole start-up delay.
- R4: An external reset gives a cold reset sequence. In normal run it leaves both flags unchanged. While halted it sets time-out=0 and power-down=1.
- R5: A watchdog overflow in normal run gives a cold reset with time-out=1 and power-down unchanged. While halted it gives a warm reset: `warm_rst_o`=1 (with `cold_rst_o`=0) through the delay, and both flags become 1.
- R6: While halted, a port bit that reads 1 in one cycle and 0 in the next, with its wake-enable bit at 1, wakes the block. After the delay, `resume_o` pulses. An edge on a bit whose enable is 0 leaves the block halted.
- R7: An interrupt request wakes the block. If one of the waking requests has its enable set and `stack_full_i`=0, `take_irq_o` pulses after the delay. Otherwise `resume_o` pulses.
- R8: An interrupt request that is already set in the cycle the halt is entered cannot wake the block during that halt.
- R9: The start-up state lasts exactly DELAY (default 1024) cycles with `clk_en_o`=0. In the next cycle `clk_en_o` returns to 1. In that same cycle the matching strobe (`resume_o` or `take_irq_o`, for a non-reset wake) is high for exactly one cycle.
- R10: When wake events coincide while halted, the winner follows this order: power-up, then external reset, then watchdog overflow, then interrupt, then port edge.
- R11: During the start-up delay, only power-up acts, and it restarts a full cold delay. Halt requests, external reset, watchdog overflow and the clear command are ignored in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; behaves as power-up |
| por_i | input | 1 | Power-up indication |
| ext_rst_i | input | 1 | External reset pin (synchronised, active high) |
| halt_req_i | input | 1 | Halt request from the core |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| wdt_clr_cmd_i | input | 1 | Watchdog-clear command from the core |
| port_i | input | PORT_W | Port pin levels |
| port_wake_en_i | input | PORT_W | Per-bit wake enable |
| irq_req_i | input | NIRQ | Interrupt request flags |
| irq_en_i | input | NIRQ | Interrupt enables |
| stack_full_i | input | 1 | Return stack is full |
| clk_en_o | output | 1 | System clock gate enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear |
| cold_rst_o | output | 1 | Cold reset, held through the start-up delay |
| warm_rst_o | output | 1 | Warm reset (program counter and stack pointer only) |
| resume_o | output | 1 | Resume-at-next-instruction strobe |
| take_irq_o | output | 1 | Take-interrupt strobe |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |

## Verification
The interesting collisions happen while halted. A single cycle can carry an external reset, a watchdog overflow, an enabled interrupt and a port falling edge all at once. The bench drives these together in one cycle, then drops the highest source and repeats, until only interrupt plus port edge remains. Each time it judges the winner from the reset output that rises and from the flag pair, or, for the last pair, from which strobe fires after the delay. A second collision is a power-up pulse arriving partway through a running start-up delay. The bench checks that the delay restarts and that the clock enable comes back exactly DELAY cycles after that pulse.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_START} hwc_state_e;
  typedef enum logic [1:0] {WK_COLD, WK_WARM, WK_RESUME, WK_IRQ} hwc_kind_e;
  typedef enum logic [2:0] {EV_NONE, EV_POR, EV_EXT, EV_WDT, EV_IRQ, EV_PORT} hwc_event_e;
endpackage

// File: rtl/hwc_edge_detect.sv
// Per-bit falling-edge finder for the wake port; only reports while armed.
module hwc_edge_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] en_i,
  input  logic         arm_i,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      prev_q <= pin_i[b];
    end
    assign fall_o[b] = arm_i & en_i[b] & prev_q & ~pin_i[b];
  end
endmodule

// File: rtl/hwc_wake_arb.sv
// Picks one wake event per cycle while halted: por > ext > wdt > irq > port.
module hwc_wake_arb
  import hwc_pkg::*;
#(
  parameter int W    = 8,
  parameter int NIRQ = 4
) (
  input  logic            por_i,
  input  logic            ext_i,
  input  logic            wdt_i,
  input  logic [NIRQ-1:0] irq_wake_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            stack_full_i,
  input  logic [W-1:0]    fall_i,
  output hwc_event_e      ev_o,
  output logic            irq_take_o
);
  always_comb begin
    if (por_i)            ev_o = EV_POR;
    else if (ext_i)       ev_o = EV_EXT;
    else if (wdt_i)       ev_o = EV_WDT;
    else if (|irq_wake_i) ev_o = EV_IRQ;
    else if (|fall_i)     ev_o = EV_PORT;
    else                  ev_o = EV_NONE;
  end

  assign irq_take_o = (|(irq_wake_i & irq_en_i)) & ~stack_full_i;
endmodule

// File: rtl/hwc_startup_timer.sv
// Start-up delay counter; done_o marks the last of DELAY cycles.
module hwc_startup_timer #(
  parameter int DELAY = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic adv_i,
  output logic done_o
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) cnt_q <= '0;
    else if (adv_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NIRQ   = 4,
  parameter int DELAY  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_i,
  input  logic              ext_rst_i,
  input  logic              halt_req_i,
  input  logic              wdt_ovf_i,
  input  logic              wdt_clr_cmd_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [PORT_W-1:0] port_wake_en_i,
  input  logic [NIRQ-1:0]   irq_req_i,
  input  logic [NIRQ-1:0]   irq_en_i,
  input  logic              stack_full_i,
  output logic              clk_en_o,
  output logic              wdt_clr_o,
  output logic              cold_rst_o,
  output logic              warm_rst_o,
  output logic              resume_o,
  output logic              take_irq_o,
  output logic              to_flag_o,
  output logic              pd_flag_o
);
  hwc_state_e      st_q, st_n;
  hwc_kind_e       kind_q, kind_n;
  logic            to_n, pd_n;
  logic [NIRQ-1:0] blk_q, blk_n;
  logic            wclr_n, res_n, tirq_n;
  logic            t_load, t_adv, t_done;
  logic [PORT_W-1:0] fall;
  hwc_event_e      ev;
  logic            irq_take;

  hwc_edge_detect #(.W(PORT_W)) u_edge (
    .clk   (clk),
    .pin_i (port_i),
    .en_i  (port_wake_en_i),
    .arm_i (st_q == ST_HALT),
    .fall_o(fall)
  );

  hwc_wake_arb #(.W(PORT_W), .NIRQ(NIRQ)) u_arb (
    .por_i       (por_i),
    .ext_i       (ext_rst_i),
    .wdt_i       (wdt_ovf_i),
    .irq_wake_i  (irq_req_i & ~blk_q),
    .irq_en_i    (irq_en_i),
    .stack_full_i(stack_full_i),
    .fall_i      (fall),
    .ev_o        (ev),
    .irq_take_o  (irq_take)
  );

  hwc_startup_timer #(.DELAY(DELAY)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load_i(t_load),
    .adv_i (t_adv),
    .done_o(t_done)
  );

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    to_n   = to_flag_o;
    pd_n   = pd_flag_o;
    blk_n  = blk_q;
    wclr_n = 1'b0;
    res_n  = 1'b0;
    tirq_n = 1'b0;
    t_load = 1'b0;
    t_adv  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (por_i) begin
          st_n = ST_START; kind_n = WK_COLD; t_load = 1'b1;
          to_n = 1'b0; pd_n = 1'b0;
        end else if (ext_rst_i) begin
          st_n = ST_START; kind_n = WK_COLD; t_load = 1'b1;
        end else if (wdt_ovf_i) begin
          st_n = ST_START; kind_n = WK_COLD; t_load = 1'b1;
          to_n = 1'b1;
        end else if (halt_req_i) begin
          st_n   = ST_HALT;
          pd_n   = 1'b1;
          to_n   = 1'b0;
          wclr_n = 1'b1;
          blk_n  = irq_req_i;
        end else if (wdt_clr_cmd_i) begin
          pd_n = 1'b0;
        end
      end
      ST_HALT: begin
        unique case (ev)
          EV_POR: begin
            st_n = ST_START; kind_n = WK_COLD; t_load = 1'b1;
            to_n = 1'b0; pd_n = 1'b0;
          end
          EV_EXT: begin
            st_n = ST_START; kind_n = WK_COLD; t_load = 1'b1;
            to_n = 1'b0; pd_n = 1'b1;
          end
          EV_WDT: begin
            st_n = ST_START; kind_n = WK_WARM; t_load = 1'b1;
            to_n = 1'b1; pd_n = 1'b1;
          end
          EV_IRQ: begin
            st_n = ST_START; t_load = 1'b1;
            kind_n = irq_take ? WK_IRQ : WK_RESUME;
          end
          EV_PORT: begin
            st_n = ST_START; kind_n = WK_RESUME; t_load = 1'b1;
          end
          default: ;
        endcase
      end
      default: begin
        if (por_i) begin
          kind_n = WK_COLD; t_load = 1'b1;
          to_n = 1'b0; pd_n = 1'b0;
        end else if (t_done) begin
          st_n   = ST_RUN;
          res_n  = (kind_q == WK_RESUME);
          tirq_n = (kind_q == WK_IRQ);
        end else begin
          t_adv = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_START;
      kind_q     <= WK_COLD;
      blk_q      <= '0;
      to_flag_o  <= 1'b0;
      pd_flag_o  <= 1'b0;
      clk_en_o   <= 1'b0;
      wdt_clr_o  <= 1'b0;
      cold_rst_o <= 1'b1;
      warm_rst_o <= 1'b0;
      resume_o   <= 1'b0;
      take_irq_o <= 1'b0;
    end else begin
      st_q       <= st_n;
      kind_q     <= kind_n;
      blk_q      <= blk_n;
      to_flag_o  <= to_n;
      pd_flag_o  <= pd_n;
      clk_en_o   <= (st_n == ST_RUN);
      wdt_clr_o  <= wclr_n;
      cold_rst_o <= (st_n == ST_START) && (kind_n == WK_COLD);
      warm_rst_o <= (st_n == ST_START) && (kind_n == WK_WARM);
      resume_o   <= res_n;
      take_irq_o <= tirq_n;
    end
  end
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker
  import hwc_pkg::*;
#(
  parameter int DELAY = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       por_i,
  input logic       ext_rst_i,
  input logic       halt_req_i,
  input logic       wdt_ovf_i,
  input logic       wdt_clr_cmd_i,
  input logic       clk_en_o,
  input logic       wdt_clr_o,
  input logic       cold_rst_o,
  input logic       warm_rst_o,
  input logic       resume_o,
  input logic       take_irq_o,
  input logic       to_flag_o,
  input logic       pd_flag_o,
  input hwc_state_e st
);
  localparam int GW = $clog2(DELAY + 2) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || por_i)         gap_q <= '0;
    else if (st == ST_START)  gap_q <= gap_q + 1'b1;
    else                      gap_q <= '0;
  end

  a_r1_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && halt_req_i && !por_i && !ext_rst_i && !wdt_ovf_i)
      |=> (!clk_en_o && pd_flag_o && !to_flag_o && wdt_clr_o));

  a_r1_clr_single: assert property (@(posedge clk) disable iff (rst)
    wdt_clr_o |=> !wdt_clr_o);

  a_r2_clr_cmd: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && wdt_clr_cmd_i && !halt_req_i && !por_i && !ext_rst_i && !wdt_ovf_i)
      |=> !pd_flag_o);

  a_r3_por_flags: assert property (@(posedge clk) disable iff (rst)
    por_i |=> (cold_rst_o && !clk_en_o && !to_flag_o && !pd_flag_o));

  a_r4_reset_gates_clock: assert property (@(posedge clk) disable iff (rst)
    (cold_rst_o || warm_rst_o) |-> !clk_en_o);

  a_r5_warm_flags: assert property (@(posedge clk) disable iff (rst)
    warm_rst_o |-> (to_flag_o && pd_flag_o && !cold_rst_o));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resume_o, take_irq_o, cold_rst_o, warm_rst_o}));

  a_r9_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
    (resume_o || take_irq_o) |-> $rose(clk_en_o));

  a_r9_delay_len: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && $past(st) == ST_START) |-> (gap_q == GW'(DELAY)));

  a_r11_start_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && !por_i) |=> ($stable(to_flag_o) && $stable(pd_flag_o)));
endmodule

bind halt_wake_ctrl hwc_checker #(.DELAY(DELAY)) u_hwc_checker (
  .clk          (clk),
  .rst          (rst),
  .por_i        (por_i),
  .ext_rst_i    (ext_rst_i),
  .halt_req_i   (halt_req_i),
  .wdt_ovf_i    (wdt_ovf_i),
  .wdt_clr_cmd_i(wdt_clr_cmd_i),
  .clk_en_o     (clk_en_o),
  .wdt_clr_o    (wdt_clr_o),
  .cold_rst_o   (cold_rst_o),
  .warm_rst_o   (warm_rst_o),
  .resume_o     (resume_o),
  .take_irq_o   (take_irq_o),
  .to_flag_o    (to_flag_o),
  .pd_flag_o    (pd_flag_o),
  .st           (st_q)
);

// File: tb/halt_wake_ctrl_bench.sv
`timescale 1ns/1ps
module halt_wake_ctrl_bench;
  localparam int D = 1024;

  logic clk = 1'b0;
  logic rst, por, ext, halt, wdt, clrc, sfull;
  logic [7:0] port, pen;
  logic [3:0] ireq, ien;
  logic clk_en, wclr, cold, warm, res, tirq, to_f, pd_f;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  halt_wake_ctrl #(.PORT_W(8), .NIRQ(4), .DELAY(D)) u_halt_wake_ctrl (
    .clk(clk), .rst(rst), .por_i(por), .ext_rst_i(ext), .halt_req_i(halt),
    .wdt_ovf_i(wdt), .wdt_clr_cmd_i(clrc), .port_i(port), .port_wake_en_i(pen),
    .irq_req_i(ireq), .irq_en_i(ien), .stack_full_i(sfull),
    .clk_en_o(clk_en), .wdt_clr_o(wclr), .cold_rst_o(cold), .warm_rst_o(warm),
    .resume_o(res), .take_irq_o(tirq), .to_flag_o(to_f), .pd_flag_o(pd_f)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // m_st: 0 run, 1 halted, 2 starting; m_kind: 0 cold, 1 warm, 2 resume, 3 irq
  int m_st, m_kind, m_cnt;
  bit m_to, m_pd, e_wclr, e_res, e_tirq;
  logic [7:0] m_prev;
  logic [3:0] m_blk;

  task automatic go(input int k);
    m_st = 2; m_kind = k; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    logic [7:0] fall;
    logic [3:0] iw;
    fall = m_prev & ~port & pen;
    iw = ireq & ~m_blk;
    e_wclr = 0; e_res = 0; e_tirq = 0;
    if (rst) begin
      go(0); m_to = 0; m_pd = 0; m_blk = '0;
    end else begin
      case (m_st)
        0: begin
          if (por) begin go(0); m_to = 0; m_pd = 0; end
          else if (ext) go(0);
          else if (wdt) begin go(0); m_to = 1; end
          else if (halt) begin m_st = 1; m_pd = 1; m_to = 0; e_wclr = 1; m_blk = ireq; end
          else if (clrc) m_pd = 0;
        end
        1: begin
          if (por) begin go(0); m_to = 0; m_pd = 0; end
          else if (ext) begin go(0); m_to = 0; m_pd = 1; end
          else if (wdt) begin go(1); m_to = 1; m_pd = 1; end
          else if (iw != 0) go((((iw & ien) != 0) && !sfull) ? 3 : 2);
          else if (fall != 0) go(2);
        end
        default: begin
          if (por) begin go(0); m_to = 0; m_pd = 0; end
          else if (m_cnt == D - 1) begin
            m_st = 0; e_res = (m_kind == 2); e_tirq = (m_kind == 3);
          end else m_cnt++;
        end
      endcase
    end
    m_prev = port;
    cmp_on = 1'b1;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R9", "clk_en", clk_en, m_st == 0);
      chk("R1", "wdt_clr", wclr, e_wclr);
      chk("R3", "cold_rst", cold, (m_st == 2) && (m_kind == 0));
      chk("R5", "warm_rst", warm, (m_st == 2) && (m_kind == 1));
      chk("R6", "resume", res, e_res);
      chk("R7", "take_irq", tirq, e_tirq);
      chk("R4", "to_flag", to_f, m_to);
      chk("R2", "pd_flag", pd_f, m_pd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_run();
    for (int i = 0; i < 3000 && clk_en !== 1'b1; i++) step();
    step(2);
  endtask

  task automatic do_halt();
    halt = 1; step(); halt = 0; step(2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1; por = 0; ext = 0; halt = 0; wdt = 0; clrc = 0; sfull = 0;
    port = 8'hFF; pen = 8'h0F; ireq = 4'h0; ien = 4'h0;
    step(3);
    chk("R3", "reset cold", cold, 1); chk("R3", "reset clk_en", clk_en, 0);
    chk("R3", "reset to", to_f, 0);   chk("R3", "reset pd", pd_f, 0);
    rst = 0;
    wait_run();

    // R1 halt entry
    halt = 1; step(); halt = 0;
    chk("R1", "halt clk_en", clk_en, 0); chk("R1", "halt pd", pd_f, 1);
    chk("R1", "halt to", to_f, 0);      chk("R1", "halt wdt_clr", wclr, 1);
    step();
    chk("R1", "wdt_clr one cycle", wclr, 0);

    // R6 disabled bit ignored, then enabled bit wakes; R9 exact delay
    port[5] = 0; step(); port[5] = 1; step(3);
    chk("R6", "disabled bit stays halted", clk_en, 0);
    chk("R6", "disabled bit no start", cold | warm, 0);
    port[2] = 0; step(); port[2] = 1;
    chk("R6", "edge clk_en", clk_en, 0);
    step(D - 1);
    chk("R9", "last start cycle clk_en", clk_en, 0);
    step();
    chk("R9", "clk_en back", clk_en, 1); chk("R6", "port resume", res, 1);
    step();
    chk("R9", "resume one cycle", res, 0);

    // R7 enabled interrupt, stack free -> take
    do_halt();
    ien = 4'b0010; ireq = 4'b0010; step(); ireq = 0;
    step(D);
    chk("R7", "take irq", tirq, 1); chk("R7", "no resume", res, 0);
    step(2);

    // R7 stack full -> resume
    do_halt();
    sfull = 1; ireq = 4'b0010; step(); ireq = 0;
    step(D);
    chk("R7", "stack full resume", res, 1); chk("R7", "stack full no take", tirq, 0);
    sfull = 0; step(2);

    // R7 disabled interrupt -> resume
    do_halt();
    ireq = 4'b0001; step(); ireq = 0;
    step(D);
    chk("R7", "disabled irq resume", res, 1);
    step(2);

    // R8 pending before halt cannot wake
    ireq = 4'b0100; step();
    do_halt();
    step(5);
    chk("R8", "pending irq no wake", clk_en, 0);
    chk("R8", "pending irq no start", cold | warm, 0);
    port[0] = 0; step(); port[0] = 1; ireq = 0;
    step(D);
    chk("R8", "later port wake resume", res, 1);
    step(2);

    // R4 external reset while halted
    do_halt();
    ext = 1; step(); ext = 0;
    chk("R4", "ext halt cold", cold, 1); chk("R4", "ext halt to", to_f, 0);
    chk("R4", "ext halt pd", pd_f, 1);
    wait_run();

    // R2 clear command in run, ignored while halted
    clrc = 1; step(); clrc = 0;
    chk("R2", "clr cmd pd", pd_f, 0);
    do_halt();
    clrc = 1; step(); clrc = 0;
    chk("R2", "clr cmd ignored halted", pd_f, 1);

    // R5 watchdog while halted -> warm
    wdt = 1; step(); wdt = 0;
    chk("R5", "warm", warm, 1); chk("R5", "warm not cold", cold, 0);
    chk("R5", "warm to", to_f, 1); chk("R5", "warm pd", pd_f, 1);
    step(D);
    chk("R5", "warm done clk_en", clk_en, 1); chk("R5", "warm no strobe", res | tirq, 0);
    step(2);

    // R4 external reset in run keeps flags (1,1); R11 inputs ignored in start
    ext = 1; step(); ext = 0;
    chk("R4", "ext run cold", cold, 1); chk("R4", "ext run to", to_f, 1);
    chk("R4", "ext run pd", pd_f, 1);
    halt = 1; wdt = 1; clrc = 1; ext = 1; step(4);
    halt = 0; wdt = 0; clrc = 0; ext = 0;
    chk("R11", "start ignores to", to_f, 1); chk("R11", "start ignores pd", pd_f, 1);
    chk("R11", "start stays cold", cold, 1);
    wait_run();

    // R5 watchdog in run: to=1, pd unchanged (0)
    clrc = 1; step(); clrc = 0;
    wdt = 1; step(); wdt = 0;
    chk("R5", "wdt run cold", cold, 1); chk("R5", "wdt run to", to_f, 1);
    chk("R5", "wdt run pd", pd_f, 0);
    wait_run();

    // R10 priorities while halted
    ien = 4'b0001;
    do_halt();
    ext = 1; wdt = 1; ireq = 4'b0001; port[1] = 0; step();
    ext = 0; wdt = 0; ireq = 0; port[1] = 1;
    chk("R10", "ext beats all cold", cold, 1); chk("R10", "ext beats wdt to", to_f, 0);
    wait_run();
    do_halt();
    wdt = 1; ireq = 4'b0001; port[1] = 0; step();
    wdt = 0; ireq = 0; port[1] = 1;
    chk("R10", "wdt beats irq warm", warm, 1);
    wait_run();
    do_halt();
    ireq = 4'b0001; port[1] = 0; step();
    ireq = 0; port[1] = 1;
    step(D);
    chk("R10", "irq beats port take", tirq, 1);
    step(2);

    // R3 power-up in run and restart during start (R11)
    por = 1; step(); por = 0;
    chk("R3", "por cold", cold, 1); chk("R3", "por to", to_f, 0); chk("R3", "por pd", pd_f, 0);
    step(10);
    por = 1; step(); por = 0;
    step(D - 1);
    chk("R11", "por restart still starting", clk_en, 0);
    step();
    chk("R11", "por restart full delay", clk_en, 1);
    step(2);

    // R3 power-up while halted
    do_halt();
    por = 1; step(); por = 0;
    chk("R3", "por halt cold", cold, 1); chk("R3", "por halt pd", pd_f, 0);
    wait_run();

    summary();
    $finish;
  end
endmodule